// File: doc/BRIEF.md
# Tape Record Framing Codec

This block turns a stream of variable-length records into a byte-serial tape image held in a byte-addressed store, and walks that image back again. A write command frames the record's data bytes between two copies of a 32-bit byte-count word. It adds one filler byte when the count is odd. A file mark is a lone zero-valued count word.

Read commands parse the image forward. Record data comes out through a valid/ready byte port. Space commands skip a whole record, forward or backward, without presenting its data. Because the count word appears on both sides of the data, a reverse step needs only the word just behind the current position to find the start of the previous record.

Each command ends with a one-cycle completion pulse and a set of result flags:
- record length
- file mark crossed
- logical end of tape (second mark in a row)
- end of medium
- format error

A level output shows when the position sits at the start of the medium.

Top module: `tape_frame_codec`

## Requirements
- R1: A record write of N bytes stores, from the current position: the count N as four bytes (least significant first), then the N data bytes in the order accepted, then one zero filler byte when N is odd, then the count again as four bytes. The position advances by N + (N mod 2) + 8, and completion comes N + (N mod 2) + 9 cycles after acceptance.
- R2: A mark write (op 1), or a record write of length 0, stores four zero bytes and nothing else. The position advances by 4, and completion comes 5 cycles after acceptance.
- R3: A record read (op 2) presents the record's data bytes in medium order on the read port. A byte is held while ready is low. The read reports the count, and leaves the position just past the trailing count word.
- R4: A forward operation that meets a zero count word reports a mark with length 0 and moves the position by 4. If the previous forward operation also ended on a mark, it additionally reports logical end of tape.
- R5: Space forward (op 3) skips exactly one record. It presents no data bytes, reports the record length and leaves the position past the trailing count.
- R6: Space reverse (op 4) reads the count word in the four bytes below the position and completes 5 cycles after acceptance. For a non-zero count it moves the position back by count + (count mod 2) + 8 and reports the count. For a zero word it moves back 4 and reports a mark.
- R7: Space reverse at position 0 leaves the position unchanged, completes without mark or error, and shows the start-of-medium output high.
- R8: A forward read or space whose trailing count differs from its leading count reports a format error, while still reporting the leading count as the length.
- R9: A forward read or space that would touch a byte at or past the written extent stops and reports end of medium. A write that would touch a byte at or past the capacity MED_BYTES stops and reports end of medium.
- R10: Rewind (op 5) sets the position to 0 and completes in the cycle after acceptance, with the start-of-medium output high.
- R11: The command port is ready only while idle. A command offered while busy has no effect.
- R12: Every write moves the written extent to the end of the bytes just written, so older data beyond it reads as end of medium.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Codec idle, command accepted when valid |
| cmd_op_i | input | 3 | 0 write record, 1 write mark, 2 read, 3 space forward, 4 space reverse, 5 rewind |
| cmd_len_i | input | LEN_W | Record length for a record write |
| wr_data_i | input | 8 | Record byte to write |
| wr_valid_i | input | 1 | Write byte offered |
| wr_ready_o | output | 1 | Write byte taken this cycle |
| rd_data_o | output | 8 | Record byte read |
| rd_valid_o | output | 1 | Read byte available |
| rd_ready_i | input | 1 | Read byte consumed |
| med_addr_o | output | AW | Medium byte address |
| med_we_o | output | 1 | Medium write strobe |
| med_wdata_o | output | 8 | Medium write byte |
| med_rdata_i | input | 8 | Medium byte at med_addr_o, same cycle |
| pos_o | output | AW | Current tape position |
| done_o | output | 1 | One-cycle completion pulse |
| st_len_o | output | 32 | Record length of the completed command |
| st_mark_o | output | 1 | A file mark was crossed |
| st_eot_o | output | 1 | Second consecutive mark seen |
| st_eom_o | output | 1 | End of medium hit |
| st_fmt_o | output | 1 | Format error |
| bot_o | output | 1 | Position is zero |

## Verification
Every medium byte costs one cycle, so completion timing follows from the operation:
- rewind completes the cycle after acceptance;
- any operation that moves only a count word (mark write, mark read, a reverse step) completes 5 cycles after acceptance;
- a record write completes after N + pad + 9 cycles.

The bench drives on the falling edge and counts falling edges from acceptance until the completion pulse. It compares that count against these figures where they are fixed, and reads position and flags in the same half cycle as the pulse. Read-port timing depends on the stall pattern, so read checks compare the collected byte sequence and the final position rather than a cycle count.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  typedef enum logic [2:0] {
    OP_WREC  = 3'd0,
    OP_WMARK = 3'd1,
    OP_READ  = 3'd2,
    OP_SPF   = 3'd3,
    OP_SPR   = 3'd4,
    OP_REW   = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WHEAD, S_WDATA, S_WPAD, S_WTAIL,
    S_RHEAD, S_RDATA, S_SKIP, S_RPAD, S_RTAIL, S_RVTAIL
  } st_e;

  localparam int CW = 32;  // count word width
endpackage

// File: rtl/tfc_word_shift.sv
module tfc_word_shift #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [7:0]    byte_i,
  output logic [CW-1:0] word_nxt_o
);
  logic [CW-1:0] word_q;

  // little-endian: first byte ends in the low lane after a full word
  assign word_nxt_o = {byte_i, word_q[CW-1:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= word_nxt_o;
  end
endmodule

// File: rtl/tfc_position.sv
module tfc_position #(
  parameter int CAP = 4096,
  parameter int AW  = $clog2(CAP + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  input  logic          wr_i,
  output logic [AW-1:0] pos_o,
  output logic [AW-1:0] ext_o,
  output logic          rd_end_o,
  output logic          wr_full_o
);
  localparam logic [AW-1:0] CAP_A = AW'(CAP);

  logic [AW-1:0] pos_q, ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      ext_q <= '0;
    end else begin
      if (ld_i)       pos_q <= ld_val_i;
      else if (inc_i) pos_q <= pos_q + AW'(1);
      if (wr_i)       ext_q <= pos_q + AW'(1);  // truncate image at last write
    end
  end

  assign pos_o     = pos_q;
  assign ext_o     = ext_q;
  assign rd_end_o  = pos_q >= ext_q;
  assign wr_full_o = pos_q >= CAP_A;

  p_pos_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= CAP_A);
  p_ext_follow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ext_q == pos_q);
endmodule

// File: rtl/tape_frame_codec.sv
module tape_frame_codec
  import tfc_pkg::*;
#(
  parameter int MED_BYTES = 4096,
  parameter int LEN_W     = 16,
  parameter int AW        = $clog2(MED_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  output logic             cmd_ready_o,
  input  logic [2:0]       cmd_op_i,
  input  logic [LEN_W-1:0] cmd_len_i,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_valid_o,
  input  logic             rd_ready_i,
  output logic [AW-1:0]    med_addr_o,
  output logic             med_we_o,
  output logic [7:0]       med_wdata_o,
  input  logic [7:0]       med_rdata_i,
  output logic [AW-1:0]    pos_o,
  output logic             done_o,
  output logic [31:0]      st_len_o,
  output logic             st_mark_o,
  output logic             st_eot_o,
  output logic             st_eom_o,
  output logic             st_fmt_o,
  output logic             bot_o
);
  localparam int SW = CW + 2;  // sum width for position arithmetic

  st_e           st_q;
  op_e           op_q;
  logic [CW-1:0] cnt_q, rem_q, len_q;
  logic [1:0]    idx_q;
  logic          last_mark_q, done_q, mark_q, eot_q, eom_q, fmt_q;

  logic [AW-1:0] pos, ext;
  logic          rd_end, wr_full;
  logic [CW-1:0] wn;
  logic          pos_inc, pos_ld, sh_shift;
  logic [AW-1:0] pos_ld_val;
  logic [7:0]    cnt_byte;
  logic [SW-1:0] pos_x, ext_x, skip_tgt, back;
  logic          skip_ok, back_ok, last_byte;
  op_e           cmd_op;

  assign cmd_op = op_e'(cmd_op_i);

  tfc_position #(.CAP(MED_BYTES), .AW(AW)) u_pos (
    .clk_i, .rst_ni,
    .inc_i(pos_inc), .ld_i(pos_ld), .ld_val_i(pos_ld_val), .wr_i(med_we_o),
    .pos_o(pos), .ext_o(ext), .rd_end_o(rd_end), .wr_full_o(wr_full)
  );

  tfc_word_shift #(.CW(CW)) u_shift (
    .clk_i, .rst_ni, .shift_i(sh_shift), .byte_i(med_rdata_i), .word_nxt_o(wn)
  );

  assign pos_x     = SW'(pos);
  assign ext_x     = SW'(ext);
  assign skip_tgt  = pos_x + SW'(cnt_q) + SW'(cnt_q[0]);
  assign skip_ok   = skip_tgt + SW'(4) <= ext_x;
  assign back      = SW'(wn) + SW'(wn[0]) + SW'(8);
  assign back_ok   = back <= pos_x;
  assign last_byte = idx_q == 2'd3;

  always_comb begin
    case (idx_q)
      2'd0:    cnt_byte = cnt_q[7:0];
      2'd1:    cnt_byte = cnt_q[15:8];
      2'd2:    cnt_byte = cnt_q[23:16];
      default: cnt_byte = cnt_q[31:24];
    endcase
  end

  assign med_addr_o = (st_q == S_RVTAIL) ? pos - AW'(4) + AW'(idx_q) : pos;

  // datapath strobes
  always_comb begin
    pos_inc     = 1'b0;
    pos_ld      = 1'b0;
    pos_ld_val  = '0;
    sh_shift    = 1'b0;
    med_we_o    = 1'b0;
    med_wdata_o = '0;
    case (st_q)
      S_IDLE: if (cmd_valid_i && cmd_op == OP_REW) pos_ld = 1'b1;
      S_WHEAD, S_WTAIL: if (!wr_full) begin
        med_we_o = 1'b1; med_wdata_o = cnt_byte; pos_inc = 1'b1;
      end
      S_WDATA: if (!wr_full && wr_valid_i) begin
        med_we_o = 1'b1; med_wdata_o = wr_data_i; pos_inc = 1'b1;
      end
      S_WPAD: if (!wr_full) begin
        med_we_o = 1'b1; pos_inc = 1'b1;
      end
      S_RHEAD, S_RTAIL: if (!rd_end) begin
        sh_shift = 1'b1; pos_inc = 1'b1;
      end
      S_RDATA: pos_inc = !rd_end && rd_ready_i;
      S_RPAD:  pos_inc = !rd_end;
      S_SKIP: if (skip_ok) begin
        pos_ld = 1'b1; pos_ld_val = skip_tgt[AW-1:0];
      end
      S_RVTAIL: begin
        sh_shift = 1'b1;
        if (last_byte) begin
          if (wn == '0) begin
            pos_ld = 1'b1; pos_ld_val = pos - AW'(4);
          end else if (back_ok) begin
            pos_ld = 1'b1; pos_ld_val = pos - back[AW-1:0];
          end
        end
      end
      default: ;
    endcase
  end

  assign cmd_ready_o = st_q == S_IDLE;
  assign wr_ready_o  = st_q == S_WDATA && !wr_full;
  assign rd_valid_o  = st_q == S_RDATA && !rd_end;
  assign rd_data_o   = med_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; op_q <= OP_WREC;
      cnt_q <= '0; rem_q <= '0; len_q <= '0; idx_q <= '0;
      last_mark_q <= 1'b0; done_q <= 1'b0;
      mark_q <= 1'b0; eot_q <= 1'b0; eom_q <= 1'b0; fmt_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        S_IDLE: if (cmd_valid_i) begin
          op_q  <= cmd_op;
          idx_q <= '0;
          len_q <= '0;
          {mark_q, eot_q, eom_q, fmt_q} <= '0;
          case (cmd_op)
            OP_WREC:  begin cnt_q <= CW'(cmd_len_i); st_q <= S_WHEAD; end
            OP_WMARK: begin cnt_q <= '0; st_q <= S_WHEAD; end
            OP_READ, OP_SPF: st_q <= S_RHEAD;
            OP_SPR: if (pos < AW'(4)) done_q <= 1'b1;
                    else st_q <= S_RVTAIL;
            OP_REW:  begin last_mark_q <= 1'b0; done_q <= 1'b1; end
            default: done_q <= 1'b1;
          endcase
        end
        S_WHEAD: begin
          last_mark_q <= 1'b0;
          if (wr_full) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            if (last_byte) begin
              if (cnt_q == '0) begin
                done_q <= 1'b1; st_q <= S_IDLE;
              end else begin
                rem_q <= cnt_q; st_q <= S_WDATA;
              end
            end
          end
        end
        S_WDATA: begin
          if (wr_full) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (wr_valid_i) begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) st_q <= cnt_q[0] ? S_WPAD : S_WTAIL;
          end
        end
        S_WPAD: begin
          if (wr_full) eom_q <= 1'b1;
          done_q <= wr_full;
          st_q   <= wr_full ? S_IDLE : S_WTAIL;
        end
        S_WTAIL: begin
          if (wr_full) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            if (last_byte) begin
              len_q <= cnt_q; done_q <= 1'b1; st_q <= S_IDLE;
            end
          end
        end
        S_RHEAD: begin
          if (rd_end) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            if (last_byte) begin
              cnt_q <= wn;
              len_q <= wn;
              if (wn == '0) begin
                mark_q <= 1'b1; eot_q <= last_mark_q; last_mark_q <= 1'b1;
                done_q <= 1'b1; st_q <= S_IDLE;
              end else begin
                last_mark_q <= 1'b0;
                rem_q <= wn;
                st_q  <= (op_q == OP_READ) ? S_RDATA : S_SKIP;
              end
            end
          end
        end
        S_RDATA: begin
          if (rd_end) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else if (rd_ready_i) begin
            rem_q <= rem_q - CW'(1);
            if (rem_q == CW'(1)) st_q <= cnt_q[0] ? S_RPAD : S_RTAIL;
          end
        end
        S_SKIP: begin
          if (!skip_ok) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else st_q <= S_RTAIL;
        end
        S_RPAD: begin
          if (rd_end) eom_q <= 1'b1;
          done_q <= rd_end;
          st_q   <= rd_end ? S_IDLE : S_RTAIL;
        end
        S_RTAIL: begin
          if (rd_end) begin
            eom_q <= 1'b1; done_q <= 1'b1; st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
            if (last_byte) begin
              fmt_q <= wn != cnt_q; done_q <= 1'b1; st_q <= S_IDLE;
            end
          end
        end
        S_RVTAIL: begin
          idx_q <= idx_q + 2'd1;
          if (last_byte) begin
            last_mark_q <= 1'b0;
            done_q <= 1'b1;
            st_q   <= S_IDLE;
            if (wn == '0)   mark_q <= 1'b1;
            else if (back_ok) len_q <= wn;
            else              fmt_q <= 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign pos_o     = pos;
  assign done_o    = done_q;
  assign st_len_o  = len_q;
  assign st_mark_o = mark_q;
  assign st_eot_o  = eot_q;
  assign st_eom_o  = eom_q;
  assign st_fmt_o  = fmt_q;
  assign bot_o     = pos == '0;

  p_wr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    med_we_o |=> pos_o == $past(pos_o) + AW'(1));
  p_rd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(pos_o));
  p_rd_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !med_we_o);
  p_mark_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && st_mark_o |-> st_len_o == '0);
  p_rewind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o && cmd_op_i == 3'd5 |=> done_o && pos_o == '0 && bot_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
endmodule

// File: tb/tape_frame_codec_tb_top.sv
module tape_frame_codec_tb_top;
  localparam int MB = 64;
  localparam int AW = $clog2(MB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          cmd_valid = 1'b0, cmd_ready;
  logic [2:0]    cmd_op = '0;
  logic [15:0]   cmd_len = '0;
  logic [7:0]    wr_data, rd_data, med_wdata, med_rdata;
  logic          wr_valid, wr_ready, rd_valid, rd_ready, med_we;
  logic [AW-1:0] med_addr, pos;
  logic          done, mark, eot, eom, fmt, bot;
  logic [31:0]   slen;

  tape_frame_codec #(.MED_BYTES(MB), .LEN_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op), .cmd_len_i(cmd_len),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready),
    .med_addr_o(med_addr), .med_we_o(med_we), .med_wdata_o(med_wdata), .med_rdata_i(med_rdata),
    .pos_o(pos), .done_o(done), .st_len_o(slen), .st_mark_o(mark), .st_eot_o(eot),
    .st_eom_o(eom), .st_fmt_o(fmt), .bot_o(bot)
  );

  // medium model, feeder and sink
  logic [7:0] mem [0:127];
  logic       poke_en = 1'b0;
  logic [6:0] poke_addr = '0;
  logic [7:0] poke_val = '0;
  int         feed_cnt = 0, feed_base = 0, sink_cnt = 0, tick = 0;
  logic       feed_en = 1'b0, sink_en = 1'b0, stall = 1'b0;
  logic [7:0] feed_seed = '0;
  logic [7:0] got [0:63];

  assign med_rdata = mem[7'(med_addr)];
  assign wr_valid  = feed_en;
  assign wr_data   = feed_seed + 8'(feed_cnt - feed_base);
  assign rd_ready  = sink_en && (!stall || tick[0]);

  initial for (int i = 0; i < 128; i++) mem[i] = 8'hEE;

  always @(posedge clk) begin
    tick <= tick + 1;
    if (med_we) mem[7'(med_addr)] <= med_wdata;
    if (poke_en) mem[poke_addr] <= poke_val;
    if (wr_valid && wr_ready) feed_cnt <= feed_cnt + 1;
    if (rd_valid && rd_ready) begin
      got[sink_cnt[5:0]] <= rd_data;
      sink_cnt <= sink_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] op, input int len, output int cyc);
    @(negedge clk);
    cmd_op = op; cmd_len = 16'(len); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R11 completion timeout", 0, 1);
  endtask

  task automatic wr_rec(input int len, input logic [7:0] seed, output int cyc);
    feed_seed = seed; feed_base = feed_cnt; feed_en = 1'b1;
    run(3'd0, len, cyc);
    feed_en = 1'b0;
  endtask

  task automatic poke(input int a, input logic [7:0] v);
    @(negedge clk);
    poke_addr = 7'(a); poke_val = v; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R11 ready after reset", int'(cmd_ready), 1);
    chk("R10 pos after reset", int'(pos), 0);
    chk("R7 bot after reset", int'(bot), 1);
    chk("R11 no done after reset", int'(done), 0);
  endtask

  task automatic t_write_layout();
    int cyc;
    wr_rec(5, 8'hA0, cyc);
    chk("R1 write cycles", cyc, 15);
    chk("R1 write pos", int'(pos), 14);
    chk("R1 head count", int'(mem[0]), 5);
    chk("R1 head upper", int'({mem[1], mem[2], mem[3]}), 0);
    for (int i = 0; i < 5; i++) chk("R1 data byte", int'(mem[4+i]), 'hA0 + i);
    chk("R1 pad byte", int'(mem[9]), 0);
    chk("R1 tail count", int'({mem[13], mem[12], mem[11], mem[10]}), 5);
    run(3'd1, 0, cyc);
    chk("R2 mark cycles", cyc, 5);
    chk("R2 mark pos", int'(pos), 18);
    chk("R2 mark word", int'({mem[17], mem[16], mem[15], mem[14]}), 0);
    wr_rec(4, 8'h30, cyc);
    chk("R1 even record pos", int'(pos), 30);
    wr_rec(0, 8'h00, cyc);
    chk("R2 zero length record pos", int'(pos), 34);
    run(3'd1, 0, cyc);
    chk("R2 second mark pos", int'(pos), 38);
  endtask

  task automatic t_rewind();
    int cyc;
    run(3'd5, 0, cyc);
    chk("R10 rewind cycles", cyc, 1);
    chk("R10 rewind pos", int'(pos), 0);
    chk("R10 rewind bot", int'(bot), 1);
  endtask

  task automatic t_forward();
    int cyc, base;
    base = sink_cnt; sink_en = 1'b1; stall = 1'b1;
    run(3'd2, 0, cyc);
    sink_en = 1'b0; stall = 1'b0;
    chk("R3 bytes received", sink_cnt - base, 5);
    for (int i = 0; i < 5; i++) chk("R3 byte order", int'(got[6'(base + i)]), 'hA0 + i);
    chk("R3 length", int'(slen), 5);
    chk("R3 pos after read", int'(pos), 14);
    chk("R8 no format error", int'(fmt), 0);
    run(3'd2, 0, cyc);
    chk("R4 mark flag", int'(mark), 1);
    chk("R4 mark pos", int'(pos), 18);
    chk("R4 single mark not eot", int'(eot), 0);
    base = sink_cnt; sink_en = 1'b1;
    run(3'd3, 0, cyc);
    sink_en = 1'b0;
    chk("R5 no data presented", sink_cnt - base, 0);
    chk("R5 length", int'(slen), 4);
    chk("R5 pos", int'(pos), 30);
    run(3'd2, 0, cyc);
    chk("R4 mark after record", int'(mark), 1);
    chk("R4 eot clear", int'(eot), 0);
    run(3'd2, 0, cyc);
    chk("R4 eot on second mark", int'(eot), 1);
    chk("R4 pos", int'(pos), 38);
    base = sink_cnt; sink_en = 1'b1;
    run(3'd2, 0, cyc);
    sink_en = 1'b0;
    chk("R9 eom at extent", int'(eom), 1);
    chk("R9 pos unchanged", int'(pos), 38);
    chk("R9 no data", sink_cnt - base, 0);
  endtask

  task automatic t_reverse();
    int cyc;
    run(3'd4, 0, cyc);
    chk("R6 reverse cycles", cyc, 5);
    chk("R6 reverse mark", int'(mark), 1);
    chk("R6 reverse mark pos", int'(pos), 34);
    run(3'd4, 0, cyc);
    chk("R6 reverse mark pos 2", int'(pos), 30);
    run(3'd4, 0, cyc);
    chk("R6 reverse even len", int'(slen), 4);
    chk("R6 reverse even pos", int'(pos), 18);
    run(3'd4, 0, cyc);
    chk("R6 reverse mark pos 3", int'(pos), 14);
    run(3'd4, 0, cyc);
    chk("R6 reverse odd len", int'(slen), 5);
    chk("R6 reverse odd pos", int'(pos), 0);
    run(3'd4, 0, cyc);
    chk("R7 pos held at start", int'(pos), 0);
    chk("R7 bot", int'(bot), 1);
    chk("R7 no mark", int'(mark), 0);
    chk("R7 no error", int'(fmt | eom), 0);
  endtask

  task automatic t_format();
    int cyc;
    poke(10, 8'h06);
    run(3'd5, 0, cyc);
    sink_en = 1'b1;
    run(3'd2, 0, cyc);
    sink_en = 1'b0;
    chk("R8 format error", int'(fmt), 1);
    chk("R8 length from head", int'(slen), 5);
    poke(10, 8'h05);
  endtask

  task automatic t_truncate();
    int cyc;
    run(3'd5, 0, cyc);
    run(3'd3, 0, cyc);
    wr_rec(2, 8'h50, cyc);
    chk("R12 overwrite pos", int'(pos), 24);
    run(3'd5, 0, cyc);
    run(3'd3, 0, cyc);
    run(3'd3, 0, cyc);
    chk("R12 new record spaced", int'(pos), 24);
    run(3'd2, 0, cyc);
    chk("R12 old data cut off", int'(eom), 1);
  endtask

  task automatic t_capacity();
    int cyc, base;
    run(3'd5, 0, cyc);
    base = feed_cnt;
    wr_rec(60, 8'h01, cyc);
    chk("R9 capacity eom", int'(eom), 1);
    chk("R9 capacity pos", int'(pos), 64);
    chk("R9 data accepted", feed_cnt - base, 60);
  endtask

  task automatic t_busy();
    int cyc;
    run(3'd5, 0, cyc);
    feed_seed = 8'h10; feed_base = feed_cnt; feed_en = 1'b1;
    @(negedge clk);
    cmd_op = 3'd0; cmd_len = 16'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R11 busy not ready", int'(cmd_ready), 0);
    cmd_op = 3'd5; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    feed_en = 1'b0;
    chk("R11 busy command ignored", int'(pos), 12);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write_layout();
    t_rewind();
    t_forward();
    t_reverse();
    t_format();
    t_truncate();
    t_capacity();
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule